// File: doc/BRIEF.md
# Line-Strobed Table Transfer Channel

This block is one channel of a display-synchronised transfer engine. Once per frame it is pointed at a table in wide-bus memory. On every display line strobe it advances through that table and writes a burst of 1, 2 or 4 bytes to consecutive or repeated peripheral register offsets. This lets software change peripheral settings line by line without running code in the line period.

Each table entry begins with a line byte. Its low seven bits give the number of lines the entry covers. Its top bit chooses between writing fresh data on every one of those lines and writing only on the line where the entry was loaded. In direct mode the data bytes follow the line byte in the table. In indirect mode the line byte is followed by a 16-bit pointer, and the data is fetched through that pointer from a separately configured bank. A line byte of zero ends the channel until the next frame start. Every data byte moved and every pointer byte loaded is reported as a fixed cost on a cost output.

Top module: `tdc_channel`

## Requirements
- R1: The burst width and the peripheral offsets added to `cfg_periph` come from `cfg_mode`. Mode 0 writes offset 0. Mode 1 writes 0,1. Modes 2 and 6 write 0,0. Modes 3 and 7 write 0,0,1,1. Mode 4 writes 0,1,2,3. Mode 5 writes 0,1,0,1.
- R2: A serviced line strobe reads a new line byte from the table pointer, and advances that pointer by one, whenever the low 7 bits of the line counter are zero.
- R3: A fetched line byte of zero sets `done`. After that, no peripheral write occurs until the next `frame_init`.
- R4: With bit 7 of the current line byte set, a burst is written on every line of the entry. With it clear, a burst is written only on the line where the entry was fetched.
- R5: The line counter drops by one on every serviced line strobe, so an entry with count N occupies exactly N strobes.
- R6: With `cfg_indirect` high, the line byte is followed by two table bytes, low then high, that form the data pointer. Data is then read from bank `cfg_dat_bank`.
- R7: In direct mode the burst bytes are read from the table, and the table pointer advances by the burst width after each burst. In indirect mode the data pointer advances by the burst width instead.
- R8: `cost` shows 8 in each cycle that moves a data byte or loads a pointer byte, and 0 otherwise, including the line-byte fetch.
- R9: `frame_init` loads the table pointer from `cfg_tbl_start`, clears the line counter and clears `done`, so the next strobe fetches an entry.
- R10: Table and data pointers wrap within 16 bits. The bank byte of `rd_addr` never changes because of a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_init | input | 1 | Frame start strobe |
| line_stb | input | 1 | Display line strobe |
| cfg_mode | input | 3 | Burst pattern select |
| cfg_indirect | input | 1 | Indirect table mode |
| cfg_periph | input | 8 | Peripheral register base |
| cfg_tbl_start | input | 16 | Table start address |
| cfg_tbl_bank | input | 8 | Table bank |
| cfg_dat_bank | input | 8 | Indirect data bank |
| rd_en | output | 1 | Wide-bus read enable |
| rd_addr | output | 24 | Wide-bus read address {bank, offset} |
| rd_data | input | 8 | Wide-bus read data, same cycle |
| pw_en | output | 1 | Peripheral write enable |
| pw_addr | output | 8 | Peripheral register address |
| pw_data | output | 8 | Peripheral write data |
| cost | output | 8 | Cycle units charged this cycle |
| busy | output | 1 | Channel servicing a line |
| done | output | 1 | Table ended for this frame |

## Verification
The bench covers all eight burst patterns. A wrong offset table sends bytes to the wrong peripheral register. It mixes repeat and one-shot entries, where an inverted top-bit test writes on the wrong lines or shifts every later entry. Tables and indirect pointers are placed just below 0xFFFF, so a design that carries into the bank reads from a foreign bank. The bench also keeps strobing after the end marker, so a design that does not latch the end keeps fetching and writing junk.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LINE,
        ST_PLO,
        ST_PHI,
        ST_XFER
    } tdc_state_e;
endpackage

// File: rtl/tdc_lane_map.sv
module tdc_lane_map (
    input  logic [2:0] mode,
    input  logic [1:0] idx,
    output logic [2:0] units,
    output logic [1:0] offs
);
    always_comb begin
        case (mode)
            3'd0:             units = 3'd1;
            3'd1, 3'd2, 3'd6: units = 3'd2;
            default:          units = 3'd4;
        endcase
        case (mode)
            3'd1, 3'd5: offs = {1'b0, idx[0]};
            3'd3, 3'd7: offs = {1'b0, idx[1]};
            3'd4:       offs = idx;
            default:    offs = 2'd0;
        endcase
    end
endmodule

// File: rtl/tdc_seq.sv
module tdc_seq
    import tdc_pkg::*;
#(
    parameter int PW     = 16,
    parameter int BW     = 8,
    parameter int DW     = 8,
    parameter int CHARGE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_init,
    input  logic             line_stb,
    input  logic             cfg_indirect,
    input  logic [DW-1:0]    cfg_periph,
    input  logic [PW-1:0]    cfg_tbl_start,
    input  logic [BW-1:0]    cfg_tbl_bank,
    input  logic [BW-1:0]    cfg_dat_bank,
    input  logic [2:0]       units,
    input  logic [1:0]       offs,
    output logic [1:0]       idx,
    output logic             rd_en,
    output logic [BW+PW-1:0] rd_addr,
    input  logic [DW-1:0]    rd_data,
    output logic             pw_en,
    output logic [DW-1:0]    pw_addr,
    output logic [DW-1:0]    pw_data,
    output logic [7:0]       cost,
    output logic             busy,
    output logic             done
);
    localparam logic [7:0] COST_U = 8'(CHARGE);

    typedef struct packed {
        tdc_state_e    st;
        logic [7:0]    line;
        logic [PW-1:0] tptr;
        logic [PW-1:0] dptr;
        logic [1:0]    idx;
        logic          done;
    } seq_t;

    seq_t q, d;
    logic last;

    assign last = ({1'b0, q.idx} == units - 3'd1);

    always_comb begin
        d       = q;
        rd_en   = 1'b0;
        rd_addr = '0;
        pw_en   = 1'b0;
        pw_addr = '0;
        pw_data = '0;
        cost    = 8'd0;
        if (frame_init) begin
            d.st   = ST_IDLE;
            d.line = 8'd0;
            d.tptr = cfg_tbl_start;
            d.idx  = 2'd0;
            d.done = 1'b0;
        end else begin
            case (q.st)
                ST_IDLE: begin
                    if (line_stb && !q.done) begin
                        d.idx = 2'd0;
                        if (q.line[6:0] == 7'd0)
                            d.st = ST_LINE;
                        else if (q.line[7])
                            d.st = ST_XFER;
                        else
                            d.line = q.line - 8'd1;
                    end
                end
                ST_LINE: begin
                    rd_en   = 1'b1;
                    rd_addr = {cfg_tbl_bank, q.tptr};
                    d.tptr  = q.tptr + 1'b1;
                    d.line  = 8'(rd_data);
                    if (rd_data == '0) begin
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.st = cfg_indirect ? ST_PLO : ST_XFER;
                    end
                end
                ST_PLO: begin
                    rd_en   = 1'b1;
                    rd_addr = {cfg_tbl_bank, q.tptr};
                    cost    = COST_U;
                    d.tptr  = q.tptr + 1'b1;
                    d.dptr  = {q.dptr[PW-1:8], 8'(rd_data)};
                    d.st    = ST_PHI;
                end
                ST_PHI: begin
                    rd_en   = 1'b1;
                    rd_addr = {cfg_tbl_bank, q.tptr};
                    cost    = COST_U;
                    d.tptr  = q.tptr + 1'b1;
                    d.dptr  = {8'(rd_data), q.dptr[7:0]};
                    d.st    = ST_XFER;
                end
                ST_XFER: begin
                    rd_en   = 1'b1;
                    rd_addr = cfg_indirect ? {cfg_dat_bank, q.dptr + PW'(q.idx)}
                                           : {cfg_tbl_bank, q.tptr + PW'(q.idx)};
                    pw_en   = 1'b1;
                    pw_addr = cfg_periph + DW'(offs);
                    pw_data = rd_data;
                    cost    = COST_U;
                    if (last) begin
                        if (cfg_indirect) d.dptr = q.dptr + PW'(units);
                        else              d.tptr = q.tptr + PW'(units);
                        d.line = q.line - 8'd1;
                        d.st   = ST_IDLE;
                        d.idx  = 2'd0;
                    end else begin
                        d.idx = q.idx + 2'd1;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.line <= 8'd0;
            q.tptr <= '0;
            q.dptr <= '0;
            q.idx  <= 2'd0;
            q.done <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign idx  = q.idx;
    assign busy = (q.st != ST_IDLE);
    assign done = q.done;

    AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> !pw_en); // R3
    AST_COST_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cost != 8'd0) |-> rd_en); // R8
    AST_WRITE_HAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        pw_en |-> rd_en); // R1
    AST_FETCH_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && line_stb && !q.done && q.line[6:0] == 7'd0 && !frame_init)
        |=> (rd_en && !pw_en)); // R2
    AST_SKIP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && line_stb && !q.done && q.line[6:0] != 7'd0 && !q.line[7]
         && !frame_init) |=> (q.line == $past(q.line) - 8'd1)); // R5
    AST_DIRECT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_XFER && last && !cfg_indirect && !frame_init)
        |=> (q.tptr == $past(q.tptr) + PW'($past(units)))); // R7
endmodule

// File: rtl/tdc_channel.sv
module tdc_channel #(
    parameter int PW     = 16,
    parameter int BW     = 8,
    parameter int DW     = 8,
    parameter int CHARGE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_init,
    input  logic             line_stb,
    input  logic [2:0]       cfg_mode,
    input  logic             cfg_indirect,
    input  logic [DW-1:0]    cfg_periph,
    input  logic [PW-1:0]    cfg_tbl_start,
    input  logic [BW-1:0]    cfg_tbl_bank,
    input  logic [BW-1:0]    cfg_dat_bank,
    output logic             rd_en,
    output logic [BW+PW-1:0] rd_addr,
    input  logic [DW-1:0]    rd_data,
    output logic             pw_en,
    output logic [DW-1:0]    pw_addr,
    output logic [DW-1:0]    pw_data,
    output logic [7:0]       cost,
    output logic             busy,
    output logic             done
);
    logic [2:0] units;
    logic [1:0] offs;
    logic [1:0] idx;

    tdc_lane_map u_map (
        .mode  (cfg_mode),
        .idx   (idx),
        .units (units),
        .offs  (offs)
    );

    tdc_seq #(.PW(PW), .BW(BW), .DW(DW), .CHARGE(CHARGE)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_init    (frame_init),
        .line_stb      (line_stb),
        .cfg_indirect  (cfg_indirect),
        .cfg_periph    (cfg_periph),
        .cfg_tbl_start (cfg_tbl_start),
        .cfg_tbl_bank  (cfg_tbl_bank),
        .cfg_dat_bank  (cfg_dat_bank),
        .units         (units),
        .offs          (offs),
        .idx           (idx),
        .rd_en         (rd_en),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data),
        .pw_en         (pw_en),
        .pw_addr       (pw_addr),
        .pw_data       (pw_data),
        .cost          (cost),
        .busy          (busy),
        .done          (done)
    );
endmodule

// File: tb/tdc_channel_test.sv
`timescale 1ns/1ps
module tdc_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_init = 1'b0;
    logic        line_stb = 1'b0;
    logic [2:0]  cfg_mode = 3'd0;
    logic        cfg_indirect = 1'b0;
    logic [7:0]  cfg_periph = 8'h18;
    logic [15:0] cfg_tbl_start = 16'h0100;
    logic [7:0]  cfg_tbl_bank = 8'h12;
    logic [7:0]  cfg_dat_bank = 8'h34;
    logic        rd_en, pw_en, busy, done;
    logic [23:0] rd_addr;
    logic [7:0]  rd_data, pw_addr, pw_data, cost;

    logic [7:0] tmem [0:4095];
    logic [7:0] dmem [0:4095];

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] memrd(logic [23:0] a);
        if (a[23:16] == cfg_tbl_bank) return tmem[a[11:0]];
        if (a[23:16] == cfg_dat_bank) return dmem[a[11:0]];
        return 8'hEE;
    endfunction

    assign rd_data = memrd(rd_addr);

    tdc_channel uut (
        .clk(clk), .rst_n(rst_n), .frame_init(frame_init), .line_stb(line_stb),
        .cfg_mode(cfg_mode), .cfg_indirect(cfg_indirect), .cfg_periph(cfg_periph),
        .cfg_tbl_start(cfg_tbl_start), .cfg_tbl_bank(cfg_tbl_bank),
        .cfg_dat_bank(cfg_dat_bank), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .pw_en(pw_en), .pw_addr(pw_addr), .pw_data(pw_data),
        .cost(cost), .busy(busy), .done(done)
    );

    // captured activity
    logic [7:0] cap_a [0:15];
    logic [7:0] cap_d [0:15];
    int cap_n = 0;
    int cap_cost = 0;
    always @(negedge clk) begin
        if (pw_en && cap_n < 16) begin
            cap_a[cap_n] <= pw_addr;
            cap_d[cap_n] <= pw_data;
            cap_n <= cap_n + 1;
        end
        if (cost != 8'd0) cap_cost <= cap_cost + int'(cost);
    end

    // reference model
    logic [7:0]  m_line;
    logic [15:0] m_tptr, m_dptr;
    logic        m_done;
    logic [7:0]  exp_a [0:15];
    logic [7:0]  exp_d [0:15];
    int exp_n, exp_cost;

    function automatic int burst_len(logic [2:0] m);
        case (m)
            3'd0: return 1;
            3'd1, 3'd2, 3'd6: return 2;
            default: return 4;
        endcase
    endfunction

    function automatic logic [7:0] lane_off(logic [2:0] m, int i);
        case (m)
            3'd1, 3'd5: return 8'(i % 2);
            3'd3, 3'd7: return 8'(i / 2);
            3'd4: return 8'(i);
            default: return 8'd0;
        endcase
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic model_line();
        int n = burst_len(cfg_mode);
        bit fresh = 1'b0;
        logic [7:0] b;
        exp_n = 0;
        exp_cost = 0;
        if (m_done) return;
        if (m_line[6:0] == 7'd0) begin
            b = memrd({cfg_tbl_bank, m_tptr});
            m_tptr = m_tptr + 16'd1;
            m_line = b;
            if (b == 8'd0) begin
                m_done = 1'b1;
                return;
            end
            fresh = 1'b1;
            if (cfg_indirect) begin
                m_dptr[7:0]  = memrd({cfg_tbl_bank, m_tptr});
                m_tptr = m_tptr + 16'd1;
                m_dptr[15:8] = memrd({cfg_tbl_bank, m_tptr});
                m_tptr = m_tptr + 16'd1;
                exp_cost += 16;
            end
        end
        if (fresh || m_line[7]) begin
            for (int i = 0; i < n; i++) begin
                logic [15:0] pa;
                pa = (cfg_indirect ? m_dptr : m_tptr) + 16'(i);
                exp_a[exp_n] = cfg_periph + lane_off(cfg_mode, i);
                exp_d[exp_n] = memrd({cfg_indirect ? cfg_dat_bank : cfg_tbl_bank, pa});
                exp_n++;
                exp_cost += 8;
            end
            if (cfg_indirect) m_dptr = m_dptr + 16'(n);
            else              m_tptr = m_tptr + 16'(n);
        end
        m_line = m_line - 8'd1;
    endtask

    task automatic tput(inout logic [15:0] p, input logic [7:0] v);
        tmem[p[11:0]] = v;
        p = p + 16'd1;
    endtask

    task automatic build_table(int nent, bit wrap);
        logic [15:0] p = cfg_tbl_start;
        int n = burst_len(cfg_mode);
        for (int e = 0; e < nent; e++) begin
            int cnt = 1 + int'($urandom % 3);
            bit rep = (e % 2 == 0) ? 1'b1 : 1'b0;
            if (e >= 2) rep = 1'($urandom % 2);
            tput(p, {rep, 7'(cnt)});
            if (cfg_indirect) begin
                logic [15:0] ip = (wrap && e == 0) ? 16'hFFFE : 16'($urandom);
                tput(p, ip[7:0]);
                tput(p, ip[15:8]);
            end else begin
                for (int k = 0; k < (rep ? cnt * n : n); k++) tput(p, 8'($urandom));
            end
        end
        tput(p, 8'd0);
    endtask

    task automatic run_frame(logic [2:0] m, bit ind, logic [15:0] ts, int nent,
                             bit wrap, string tag);
        int extra = 0;
        @(negedge clk);
        cfg_mode = m;
        cfg_indirect = ind;
        cfg_tbl_start = ts;
        cfg_periph = 8'($urandom);
        for (int i = 0; i < 4096; i++) dmem[i] = 8'($urandom);
        build_table(nent, wrap);
        frame_init = 1'b1;
        @(negedge clk);
        frame_init = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R9 init clears done", int'(done), 0);
        m_line = 8'd0; m_tptr = ts; m_dptr = 16'd0; m_done = 1'b0;
        for (int ln = 0; ln < 60 && extra < 2; ln++) begin
            if (m_done) extra++;
            model_line();
            line_stb = 1'b1;
            @(negedge clk);
            line_stb = 1'b0;
            repeat (10) @(negedge clk);
            chk(cap_n == exp_n, {"R2/R4/R5 write count ", tag}, cap_n, exp_n);
            for (int i = 0; i < exp_n && i < cap_n; i++) begin
                chk(cap_a[i] == exp_a[i], {"R1 periph addr ", tag}, int'(cap_a[i]), int'(exp_a[i]));
                chk(cap_d[i] == exp_d[i], {"R6/R7/R10 data ", tag}, int'(cap_d[i]), int'(exp_d[i]));
            end
            chk(cap_cost == exp_cost, {"R8 cost ", tag}, cap_cost, exp_cost);
            chk(done == m_done, {"R3 done ", tag}, int'(done), int'(m_done));
            cap_n = 0;
            cap_cost = 0;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 4096; i++) begin
            tmem[i] = 8'd0;
            dmem[i] = 8'd0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pw_en && !rd_en && !busy && !done && cost == 8'd0, "R9 reset state", int'(busy), 0);
        // every burst pattern, direct mode
        for (int m = 0; m < 8; m++) run_frame(3'(m), 1'b0, 16'h0200, 3, 1'b0, "direct");
        // every burst pattern, indirect mode
        for (int m = 0; m < 8; m++) run_frame(3'(m), 1'b1, 16'h0400, 3, 1'b0, "indirect");
        // 16-bit wrap of table and data pointers
        run_frame(3'd4, 1'b0, 16'hFFFD, 3, 1'b0, "R10 table wrap");
        run_frame(3'd3, 1'b1, 16'hFFFE, 2, 1'b1, "R10 data wrap");
        // immediate end marker
        tmem[12'h600] = 8'd0;
        run_frame(3'd1, 1'b0, 16'h0600, 0, 1'b0, "R3 empty table");
        // random frames
        for (int r = 0; r < 20; r++)
            run_frame(3'($urandom % 8), 1'($urandom % 2), 16'($urandom), 1 + int'($urandom % 4),
                      1'b0, "random");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule